// File: doc/BRIEF.md
# Two-Zone Clock Skew Balancing Controller

This block closes the digital half of a skew correction loop between two clock distribution zones, a left spine and a right spine. One phase comparator looks at the feedback clocks coming back from both zones. On each sample it reports which zone is late. The controller filters that stream of decisions. It then moves one of two delay settings, one per zone, so that the late zone speeds up or the early zone slows down. Each setting is a thermometer code held in a shift register and would steer an adjustable delay line. The phase comparator and the delay lines sit outside this block.

The loop balances the two zones against each other, with no external reference. Removing delay from the late zone is preferred. Delay is added to the early zone only once the late zone has no delay left to give up. A run filter acts on a decision only after the same direction has repeated a set number of times, which stops the codes dithering around the balance point. A lock flag rises once the corrections have alternated direction for a set number of consecutive steps.

Top module: `dsk_ctrl`

## Requirements
- R1: While reset is held, and on the first cycle after it, each code holds its mid-range value: the lowest CODE_W/2 bits are ones and the rest are zeros. With the defaults this is 16'h00FF. `locked` is 0.
- R2: Each code is a thermometer code. Bit i is 1 exactly when i is below the setting. Adding a step shifts a 1 in at bit 0 and moves the ones upward. Removing a step shifts a 0 in at the top bit.
- R3: A correction step happens on the clock edge that samples the FILT_N-th valid sample of a run of consecutive valid samples with the same direction. Cycles with `pd_valid` low neither extend nor break the run. A sample in the opposite direction starts a new run of length 1. After a step, the run count starts again from zero.
- R4: A step with `pd_left_late`=1 removes one position from the left code if the left code is nonzero. If the left code is zero, the step adds one position to the right code instead.
- R5: A step with `pd_left_late`=0 removes one position from the right code if the right code is nonzero. If the right code is zero, the step adds one position to the left code instead.
- R6: A code that is all ones stays all ones when a step would add to it. A code that is all zeros is never decremented.
- R7: While `en` is low, both codes hold their values and phase samples are ignored. Any partial run is discarded, so counting starts afresh when `en` returns. `locked` reads 0 from the cycle after `en` is seen low.
- R8: `locked` becomes 1 on the edge of the step that completes LOCK_N consecutive alternations, where each such step is opposite in direction to the step before it. A step in the same direction as the previous one resets the alternation count. Once set, `locked` stays 1 until reset or until `en` goes low.
- R9: On any clock edge, at most one of the two codes changes, and it moves by exactly one position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Loop enable; low freezes the codes |
| pd_valid | input | 1 | Phase sample strobe |
| pd_left_late | input | 1 | Phase decision: 1 = left zone late, 0 = right zone late |
| left_code | output | CODE_W | Thermometer delay setting of the left zone |
| right_code | output | CODE_W | Thermometer delay setting of the right zone |
| locked | output | 1 | Loop has settled into alternating corrections |

## Verification
A run counter that is off by one shows up on the edge of the step itself. The affected code moves one valid sample early or late, so the cycle-exact comparison of both codes catches it at once. Wrong steering shows as the wrong code moving on that same edge, or as a zero code being decremented. This is seen most clearly when the left code is drained and the correction must move over to the right zone. Corrupt lock history shows up as `locked` rising one step early or late at the end of an alternating sequence, or as `locked` surviving a drop of `en` by more than one cycle.

// File: rtl/dsk_pkg.sv
`timescale 1ns/1ps
package dsk_pkg;
    typedef enum logic {
        DIR_RIGHT_LATE = 1'b0,
        DIR_LEFT_LATE  = 1'b1
    } dsk_dir_e;

    typedef enum logic [1:0] {
        ZC_HOLD = 2'd0,
        ZC_ADD  = 2'd1,
        ZC_SUB  = 2'd2
    } zone_cmd_e;

    localparam int ZONE_L = 0;
    localparam int ZONE_R = 1;
    localparam int NUM_ZONES = 2;
endpackage

// File: rtl/dsk_filter.sv
`timescale 1ns/1ps
module dsk_filter
    import dsk_pkg::*;
#(
    parameter int FILT_N = 4
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     en,
    input  logic     valid,
    input  dsk_dir_e dir,
    output logic     step,
    output dsk_dir_e step_dir
);
    localparam int CW = $clog2(FILT_N + 1);
    localparam logic [CW-1:0] RUN_TARGET = CW'(FILT_N);

    typedef struct packed {
        logic [CW-1:0] run;
        dsk_dir_e      last;
    } filt_st_t;

    filt_st_t st_d, st_q;
    logic [CW-1:0] run_next;

    always_comb begin
        st_d     = st_q;
        step     = 1'b0;
        step_dir = dir;
        run_next = '0;
        if (!en) begin
            st_d.run = '0;
        end else if (valid) begin
            run_next  = (dir == st_q.last && st_q.run != '0) ? st_q.run + 1'b1 : CW'(1);
            st_d.last = dir;
            if (run_next == RUN_TARGET) begin
                step     = 1'b1;
                st_d.run = '0;
            end else begin
                st_d.run = run_next;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{run: '0, last: DIR_RIGHT_LATE};
        end else begin
            st_q <= st_d;
        end
    end

    // R3: the stored run never reaches the step threshold
    a_r3_run_below_target: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.run < RUN_TARGET);

    // R7: a disabled cycle leaves no run behind
    a_r7_run_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> st_q.run == '0);
endmodule

// File: rtl/dsk_zone.sv
`timescale 1ns/1ps
module dsk_zone
    import dsk_pkg::*;
#(
    parameter int CODE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  zone_cmd_e         cmd,
    output logic [CODE_W-1:0] code,
    output logic              is_zero
);
    localparam logic [CODE_W-1:0] MID_CODE = {CODE_W{1'b1}} >> (CODE_W - CODE_W / 2);

    logic [CODE_W-1:0] code_d, code_q;

    always_comb begin
        code_d = code_q;
        unique case (cmd)
            ZC_ADD:  code_d = {code_q[CODE_W-2:0], 1'b1};
            ZC_SUB:  code_d = {1'b0, code_q[CODE_W-1:1]};
            default: code_d = code_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= MID_CODE;
        end else begin
            code_q <= code_d;
        end
    end

    assign code    = code_q;
    assign is_zero = ~code_q[0];

    // R2: the register always holds a contiguous run of ones from bit 0
    a_r2_thermometer: assert property (@(posedge clk) disable iff (!rst_n)
        ((code_q + 1'b1) & code_q) == '0);

    // R6: removing from an empty setting leaves it empty
    a_r6_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (code_q == '0) && (cmd == ZC_SUB) |=> code_q == '0);
endmodule

// File: rtl/dsk_lock.sv
`timescale 1ns/1ps
module dsk_lock
    import dsk_pkg::*;
#(
    parameter int LOCK_N = 4
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     en,
    input  logic     step,
    input  dsk_dir_e step_dir,
    output logic     locked
);
    localparam int LW = $clog2(LOCK_N + 1);
    localparam logic [LW-1:0] ALT_TARGET = LW'(LOCK_N);

    typedef struct packed {
        logic          have_prev;
        dsk_dir_e      prev_dir;
        logic [LW-1:0] alt;
        logic          locked;
    } lock_st_t;

    lock_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!en) begin
            st_d = '{have_prev: 1'b0, prev_dir: DIR_RIGHT_LATE, alt: '0, locked: 1'b0};
        end else if (step) begin
            if (st_q.have_prev && step_dir != st_q.prev_dir) begin
                if (st_q.alt != ALT_TARGET) st_d.alt = st_q.alt + 1'b1;
            end else begin
                st_d.alt = '0;
            end
            st_d.have_prev = 1'b1;
            st_d.prev_dir  = step_dir;
            if (st_d.alt == ALT_TARGET) st_d.locked = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{have_prev: 1'b0, prev_dir: DIR_RIGHT_LATE, alt: '0, locked: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign locked = st_q.locked;

    // R8: lock is sticky while the loop stays enabled
    a_r8_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.locked && en |=> st_q.locked);

    // R8: lock cannot rise without a step on that edge
    a_r8_rise_on_step: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.locked && !step |=> !st_q.locked);
endmodule

// File: rtl/dsk_ctrl.sv
`timescale 1ns/1ps
module dsk_ctrl
    import dsk_pkg::*;
#(
    parameter int CODE_W = 16,
    parameter int FILT_N = 4,
    parameter int LOCK_N = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              pd_valid,
    input  logic              pd_left_late,
    output logic [CODE_W-1:0] left_code,
    output logic [CODE_W-1:0] right_code,
    output logic              locked
);
    logic              step;
    dsk_dir_e          step_dir;
    zone_cmd_e         cmd_w  [NUM_ZONES];
    logic [CODE_W-1:0] code_w [NUM_ZONES];
    logic              zero_w [NUM_ZONES];

    dsk_filter #(.FILT_N(FILT_N)) u_filter (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .valid    (pd_valid),
        .dir      (dsk_dir_e'(pd_left_late)),
        .step     (step),
        .step_dir (step_dir)
    );

    // Steering: shrink the late zone first, grow the early zone only when the late one is empty
    always_comb begin
        cmd_w[ZONE_L] = ZC_HOLD;
        cmd_w[ZONE_R] = ZC_HOLD;
        if (step) begin
            if (step_dir == DIR_LEFT_LATE) begin
                if (!zero_w[ZONE_L]) cmd_w[ZONE_L] = ZC_SUB;
                else                 cmd_w[ZONE_R] = ZC_ADD;
            end else begin
                if (!zero_w[ZONE_R]) cmd_w[ZONE_R] = ZC_SUB;
                else                 cmd_w[ZONE_L] = ZC_ADD;
            end
        end
    end

    for (genvar z = 0; z < NUM_ZONES; z++) begin : g_zone
        dsk_zone #(.CODE_W(CODE_W)) u_zone (
            .clk     (clk),
            .rst_n   (rst_n),
            .cmd     (cmd_w[z]),
            .code    (code_w[z]),
            .is_zero (zero_w[z])
        );
    end

    dsk_lock #(.LOCK_N(LOCK_N)) u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .step     (step),
        .step_dir (step_dir),
        .locked   (locked)
    );

    assign left_code  = code_w[ZONE_L];
    assign right_code = code_w[ZONE_R];

    // R7: disabled cycles freeze both settings
    a_r7_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(left_code) && $stable(right_code));

    // R7: lock drops after a disabled cycle
    a_r7_unlock: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !locked);

    // R9: never both zones in one edge
    a_r9_one_zone: assert property (@(posedge clk) disable iff (!rst_n)
        !($changed(left_code) && $changed(right_code)));

    // R9: a setting moves by at most one position per edge
    a_r9_single_pos: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(left_code) <= $countones($past(left_code)) + 1) &&
        ($countones(left_code) + 1 >= $countones($past(left_code))) &&
        ($countones(right_code) <= $countones($past(right_code)) + 1) &&
        ($countones(right_code) + 1 >= $countones($past(right_code))));

    // R3: no movement without a valid enabled sample on that edge
    a_r3_needs_sample: assert property (@(posedge clk) disable iff (!rst_n)
        !(en && pd_valid) |=> $stable(left_code) && $stable(right_code));
endmodule

// File: tb/dsk_ctrl_bench.sv
`timescale 1ns/1ps
module dsk_ctrl_bench;
    localparam int W  = 16;
    localparam int FN = 4;
    localparam int LN = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic pd_valid = 1'b0;
    logic pd_left_late = 1'b0;
    logic [W-1:0] left_code, right_code;
    logic locked;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference state, derived from the requirements
    int ml, mr, mcnt, malt;
    bit mlast, mhp, mprev, mlock;

    always #2 clk = ~clk;

    dsk_ctrl #(.CODE_W(W), .FILT_N(FN), .LOCK_N(LN)) u_dsk_ctrl (
        .clk(clk), .rst_n(rst_n), .en(en), .pd_valid(pd_valid),
        .pd_left_late(pd_left_late), .left_code(left_code),
        .right_code(right_code), .locked(locked)
    );

    function automatic logic [W-1:0] therm(int n);
        logic [W-1:0] t = '0;
        for (int i = 0; i < W; i++) if (i < n) t[i] = 1'b1;
        return t;
    endfunction

    task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        ml = W / 2; mr = W / 2; mcnt = 0; malt = 0;
        mlast = 1'b0; mhp = 1'b0; mprev = 1'b0; mlock = 1'b0;
    endtask

    task automatic model_step(bit d);
        if (d) begin
            if (ml > 0) ml--; else if (mr < W) mr++;
        end else begin
            if (mr > 0) mr--; else if (ml < W) ml++;
        end
        if (mhp && d != mprev) begin
            if (malt < LN) malt++;
        end else malt = 0;
        mhp = 1'b1; mprev = d;
        if (malt == LN) mlock = 1'b1;
    endtask

    task automatic model_edge(bit e, bit v, bit d);
        int nxt;
        if (!e) begin
            mcnt = 0; mhp = 1'b0; malt = 0; mlock = 1'b0;
        end else if (v) begin
            nxt = (d == mlast && mcnt != 0) ? mcnt + 1 : 1;
            mlast = d;
            if (nxt == FN) begin
                mcnt = 0;
                model_step(d);
            end else mcnt = nxt;
        end
    endtask

    // one clock: drive away from the edge, update model at the edge, compare after it
    task automatic cyc(bit e, bit v, bit d, string tag);
        @(negedge clk);
        en = e; pd_valid = v; pd_left_late = d;
        @(posedge clk);
        model_edge(e, v, d);
        #1;
        chk({tag, " left_code"}, left_code, therm(ml));
        chk({tag, " right_code"}, right_code, therm(mr));
        chk({tag, " locked"}, W'(locked), W'(mlock));
    endtask

    task automatic run(int n, bit d, string tag);
        for (int i = 0; i < n; i++) cyc(1'b1, 1'b1, d, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        bit bias;
        model_reset();
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset left", left_code, 16'h00FF);
        chk("R1 reset right", right_code, 16'h00FF);
        chk("R1 reset locked", W'(locked), '0);
        @(negedge clk); rst_n = 1'b1; en = 1'b1;
        @(posedge clk); #1;
        chk("R1 after release", left_code, 16'h00FF);

        // R3: invalid cycles do not break a run
        run(3, 1'b1, "R3 partial run");
        chk("R3 no step yet", left_code, therm(8));
        cyc(1'b1, 1'b0, 1'b0, "R3 gap");
        cyc(1'b1, 1'b1, 1'b1, "R3 fourth sample");
        chk("R4 left shrinks", left_code, therm(7));

        // R3: opposite direction restarts the run
        run(3, 1'b1, "R3 left run");
        run(3, 1'b0, "R3 broken run");
        chk("R3 no step on broken run", right_code, therm(8));
        cyc(1'b1, 1'b1, 1'b0, "R5 right step");
        chk("R5 right shrinks", right_code, therm(7));

        // R4: drain left, then right grows
        run(7 * FN, 1'b1, "R4 drain left");
        chk("R4 left empty", left_code, '0);
        run(FN, 1'b1, "R4 spill to right");
        chk("R4 right grows", right_code, therm(8));
        chk("R6 left stays empty", left_code, '0);

        // R6: saturate right
        run(9 * FN, 1'b1, "R6 fill right");
        chk("R6 right full", right_code, {W{1'b1}});

        // R7: disabled samples ignored, partial run discarded
        run(3, 1'b1, "R7 pre-disable run");
        for (int i = 0; i < 8; i++) cyc(1'b0, 1'b1, 1'b0, "R7 frozen");
        chk("R7 right frozen", right_code, {W{1'b1}});
        cyc(1'b1, 1'b1, 1'b0, "R7 run restarted");
        run(2, 1'b0, "R7 run restarted");
        chk("R7 no early step", right_code, {W{1'b1}});
        cyc(1'b0, 1'b0, 1'b0, "R7 clear");

        // R8: alternating steps lead to lock
        run(FN, 1'b0, "R8 step1");
        run(FN, 1'b1, "R8 step2");
        run(FN, 1'b0, "R8 step3");
        run(FN, 1'b1, "R8 step4");
        chk("R8 not locked after 3 alternations", W'(locked), '0);
        run(FN, 1'b0, "R8 step5");
        chk("R8 locked after 4 alternations", W'(locked), W'(1));
        run(FN, 1'b0, "R8 sticky");
        chk("R8 lock stays", W'(locked), W'(1));
        cyc(1'b0, 1'b0, 1'b0, "R7 unlock");
        chk("R7 locked cleared", W'(locked), '0);

        // random phase: biased direction, sparse strobes, occasional disable
        void'($urandom(32'h5EED_0042));
        bias = 1'b0;
        for (int i = 0; i < 4000; i++) begin
            bit e, v, d;
            if ($urandom_range(0, 199) == 0) bias = ~bias;
            e = ($urandom_range(0, 99) < 96);
            v = ($urandom_range(0, 99) < 70);
            d = ($urandom_range(0, 99) < 65) ? bias : ~bias;
            cyc(e, v, d, "R9 random");
        end

        // reset in mid-operation returns to mid-range
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #1;
        model_reset();
        chk("R1 re-reset left", left_code, 16'h00FF);
        chk("R1 re-reset right", right_code, 16'h00FF);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule